// File: doc/BRIEF.md
# Window Watchdog Supervisor

This block supervises a software heartbeat. A processor toggles the kick input, and each falling edge of that input counts as a heartbeat. If the heartbeats stop, or in window mode arrive too soon, the block pulses an active-low reset output for a programmed number of cycles. A second active-low output flags persistent misbehaviour. It goes low after three faults in a row, and it returns high only after three good heartbeats in a row. The two thresholds give the output hysteresis, so one stray event does not toggle it.

A supply-good level holds the reset output low while it is low, and for a further reset period after it returns. A disable level switches the heartbeat watchdog off. The timeout, the closed-window width and the reset pulse length are static cycle counts, with the closed window strictly shorter than the timeout and the reset length at least 1. The kick input is asynchronous and is synchronised inside the block.

Top module: `wdg_supervisor`

## Requirements
- R1: A synchronous reset (`rst` high) drives `rst_n_o` low and `fault_n_o` high. After the last edge that samples `rst` high, `rst_n_o` rises on the `reset_cycles_i`-th following rising edge, provided `supply_ok_i` is high.
- R2: `kick_i` passes through two synchroniser flops. A high-to-low change is acted on at the third rising edge after it is applied. A low level held for many cycles counts as one falling edge only.
- R3: The heartbeat counter restarts at 0 on every clear. In timeout mode (`window_mode_i` = 0), no kick edge in the `timeout_cycles_i` edges after a clear is a fault. On that edge, `rst_n_o` goes low and stays low for exactly `reset_cycles_i` cycles.
- R4: A kick edge while `rst_n_o` is high clears the heartbeat counter. Kicks spaced closer than the timeout keep `rst_n_o` high.
- R5: In window mode (`window_mode_i` = 1), a kick edge seen while the counter is below `window_cycles_i` is a fault that starts a reset pulse. In timeout mode the same early kick is a good kick.
- R6: While `rst_n_o` is low, the heartbeat counter is held at 0 and kick edges are ignored. They count neither as good kicks nor as faults.
- R7: When the third consecutive fault occurs, `fault_n_o` goes low on the same edge as the reset pulse starts.
- R8: A low `fault_n_o` returns high on the third consecutive good kick. A fault in between restarts that run.
- R9: A good kick clears the consecutive-fault run. Two faults, a good kick and two more faults leave `fault_n_o` high.
- R10: `supply_ok_i` low drives `rst_n_o` low from the next edge. `rst_n_o` rises on the `reset_cycles_i`-th edge after the last edge that samples `supply_ok_i` low. `fault_n_o` never falls while `supply_ok_i` is low.
- R11: With `wd_disable_i` high, no fault occurs. `rst_n_o` stays high and `fault_n_o` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| kick_i | input | 1 | Asynchronous heartbeat input; falling edges are kicks |
| supply_ok_i | input | 1 | Supply-good level, high when the supply is valid |
| wd_disable_i | input | 1 | High switches the heartbeat watchdog off |
| window_mode_i | input | 1 | 1 = closed-window mode, 0 = timeout-only mode |
| timeout_cycles_i | input | CNT_W | Heartbeat timeout in cycles |
| window_cycles_i | input | CNT_W | Closed-window width in cycles (less than timeout) |
| reset_cycles_i | input | CNT_W | Reset pulse length in cycles (at least 1) |
| rst_n_o | output | 1 | Active-low reset output, registered |
| fault_n_o | output | 1 | Active-low persistent-fault output, registered |

## Verification
A kick edge applied to `kick_i` takes effect at the third rising edge after it is driven. A missed heartbeat takes effect at the `timeout_cycles_i`-th edge after the last clear. Both outputs change on that same edge. After a fault, the reset output stays low for `reset_cycles_i` negative-edge samples. After supply returns or synchronous reset ends, it stays low for one sample fewer, because the last low level is registered first. A behavioural model in the bench advances on each rising edge, and both outputs are compared against it at every falling edge. Directed checks count low samples over windows whose lengths are derived from these latencies.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  // Per-cycle heartbeat classification from the timer
  typedef struct packed {
    logic good;   // accepted kick
    logic early;  // kick inside the closed window
    logic late;   // timeout expired without a kick
  } wd_evt_t;

  function automatic logic evt_is_fault(wd_evt_t e);
    return e.early | e.late;
  endfunction
endpackage

// File: rtl/wdg_kick_sync.sv
module wdg_kick_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic kick_i,
  output logic kick_fall_o
);
  // sr[0..SYNC_STAGES-1] synchronise, sr[SYNC_STAGES] holds the previous level
  logic [SYNC_STAGES:0] sr;

  always_ff @(posedge clk) begin
    if (rst) sr <= '1;
    else     sr <= {sr[SYNC_STAGES-1:0], kick_i};
  end

  assign kick_fall_o = sr[SYNC_STAGES] & ~sr[SYNC_STAGES-1];
endmodule

// File: rtl/wdg_timer.sv
module wdg_timer
  import wdg_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active_i,
  input  logic             window_mode_i,
  input  logic             kick_fall_i,
  input  logic [CNT_W-1:0] timeout_cycles_i,
  input  logic [CNT_W-1:0] window_cycles_i,
  output wd_evt_t          evt_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             too_early;
  logic             expired;

  assign too_early = window_mode_i && (cnt_q < window_cycles_i);
  assign expired   = (cnt_q == timeout_cycles_i - CNT_W'(1));

  always_comb begin
    evt_o       = '0;
    evt_o.early = active_i & kick_fall_i & too_early;
    evt_o.good  = active_i & kick_fall_i & ~too_early;
    evt_o.late  = active_i & ~kick_fall_i & expired;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (!active_i || kick_fall_i || evt_o.late) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/wdg_reset_gen.sv
module wdg_reset_gen #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             supply_ok_i,
  input  logic             fault_i,
  input  logic [CNT_W-1:0] reset_cycles_i,
  output logic             rst_n_o
);
  logic [CNT_W-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rst_n_o <= 1'b0;
      hold_q  <= '0;
    end else if (!supply_ok_i || fault_i) begin
      rst_n_o <= 1'b0;
      hold_q  <= '0;
    end else if (!rst_n_o) begin
      if (hold_q == reset_cycles_i - CNT_W'(1)) rst_n_o <= 1'b1;
      hold_q <= hold_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/wdg_fault_hyst.sv
module wdg_fault_hyst #(
  parameter int RUN_LEN = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic fault_i,
  input  logic good_i,
  output logic fault_n_o
);
  localparam int RW = $clog2(RUN_LEN + 1);
  localparam logic [RW-1:0] RUN_MAX  = RW'(RUN_LEN);
  localparam logic [RW-1:0] RUN_LAST = RW'(RUN_LEN - 1);

  logic [RW-1:0] bad_run_q;
  logic [RW-1:0] good_run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bad_run_q  <= '0;
      good_run_q <= '0;
      fault_n_o  <= 1'b1;
    end else if (fault_i) begin
      good_run_q <= '0;
      if (bad_run_q != RUN_MAX) bad_run_q <= bad_run_q + RW'(1);
      if (bad_run_q == RUN_LAST) fault_n_o <= 1'b0;
    end else if (good_i) begin
      bad_run_q <= '0;
      if (!fault_n_o) begin
        if (good_run_q == RUN_LAST) begin
          fault_n_o  <= 1'b1;
          good_run_q <= '0;
        end else begin
          good_run_q <= good_run_q + RW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/wdg_supervisor.sv
module wdg_supervisor
  import wdg_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int RUN_LEN     = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             kick_i,
  input  logic             supply_ok_i,
  input  logic             wd_disable_i,
  input  logic             window_mode_i,
  input  logic [CNT_W-1:0] timeout_cycles_i,
  input  logic [CNT_W-1:0] window_cycles_i,
  input  logic [CNT_W-1:0] reset_cycles_i,
  output logic             rst_n_o,
  output logic             fault_n_o
);
  logic    kick_fall;
  logic    wd_active;
  wd_evt_t evt;
  logic    wd_fault;

  wdg_kick_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .kick_i(kick_i), .kick_fall_o(kick_fall)
  );

  // Heartbeat timing runs only out of reset, with supply good and not disabled
  assign wd_active = rst_n_o & supply_ok_i & ~wd_disable_i;

  wdg_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .active_i(wd_active), .window_mode_i(window_mode_i),
    .kick_fall_i(kick_fall), .timeout_cycles_i(timeout_cycles_i),
    .window_cycles_i(window_cycles_i), .evt_o(evt)
  );

  assign wd_fault = evt_is_fault(evt);

  wdg_reset_gen #(.CNT_W(CNT_W)) u_rstgen (
    .clk(clk), .rst(rst), .supply_ok_i(supply_ok_i), .fault_i(wd_fault),
    .reset_cycles_i(reset_cycles_i), .rst_n_o(rst_n_o)
  );

  wdg_fault_hyst #(.RUN_LEN(RUN_LEN)) u_hyst (
    .clk(clk), .rst(rst), .fault_i(wd_fault), .good_i(evt.good),
    .fault_n_o(fault_n_o)
  );
endmodule

// File: rtl/wdg_supervisor_chk.sv
module wdg_supervisor_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             supply_ok_i,
  input logic             wd_disable_i,
  input logic [CNT_W-1:0] reset_cycles_i,
  input logic             rst_n_o,
  input logic             fault_n_o
);
  logic [31:0] low_len;

  always_ff @(posedge clk) begin
    if (rst)           low_len <= '0;
    else if (!rst_n_o) low_len <= low_len + 32'd1;
    else               low_len <= '0;
  end

  // R3 / R10: every reset pulse lasts at least the programmed length
  assert_pulse_len_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_n_o) |-> (low_len >= 32'(reset_cycles_i)));

  // R10: supply low forces reset from the next edge
  assert_supply_holds_reset_R10: assert property (@(posedge clk) disable iff (rst)
    !supply_ok_i |=> !rst_n_o);

  // R10: fault output cannot fall while supply is low
  assert_no_fault_on_low_supply_R10: assert property (@(posedge clk) disable iff (rst)
    (!supply_ok_i && fault_n_o) |=> fault_n_o);

  // R11: disabled watchdog never starts a reset pulse
  assert_disabled_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    (wd_disable_i && supply_ok_i && rst_n_o) |=> rst_n_o);

  // R6: nothing changes the fault output while reset is held
  assert_hold_in_reset_R6: assert property (@(posedge clk) disable iff (rst)
    !rst_n_o |=> $stable(fault_n_o));

  // R7: fault output falls together with a reset pulse
  assert_fault_with_reset_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(fault_n_o) |-> !rst_n_o);

  // R8: release only comes from a good kick, never with a reset pulse
  assert_release_clean_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(fault_n_o) |-> rst_n_o);
endmodule

bind wdg_supervisor wdg_supervisor_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .supply_ok_i(supply_ok_i), .wd_disable_i(wd_disable_i),
  .reset_cycles_i(reset_cycles_i), .rst_n_o(rst_n_o), .fault_n_o(fault_n_o)
);

// File: tb/wdg_supervisor_tb_top.sv
module wdg_supervisor_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 16;
  localparam int TMO = 20;
  localparam int WIN = 6;
  localparam int RPL = 10;
  localparam int WATCHDOG_CYCLES = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic kick = 1'b1;
  logic supply_ok = 1'b1;
  logic wd_dis = 1'b0;
  logic win_mode = 1'b0;
  logic rst_n, fault_n;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 0;
  bit cmp_on = 0;
  string tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  wdg_supervisor #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst(rst), .kick_i(kick), .supply_ok_i(supply_ok),
    .wd_disable_i(wd_dis), .window_mode_i(win_mode),
    .timeout_cycles_i(CNT_W'(TMO)), .window_cycles_i(CNT_W'(WIN)),
    .reset_cycles_i(CNT_W'(RPL)), .rst_n_o(rst_n), .fault_n_o(fault_n)
  );

  // ---------------- behavioural reference model ----------------
  bit m_k1 = 1, m_k2 = 1, m_k3 = 1;
  int m_cnt = 0, m_hold = 0, m_bad = 0, m_good = 0;
  bit m_rstn = 0, m_faultn = 1;

  always @(posedge clk) begin
    bit fall, act, early, good, late, flt;
    if (rst) begin
      m_k1 = 1; m_k2 = 1; m_k3 = 1;
      m_cnt = 0; m_hold = 0; m_bad = 0; m_good = 0;
      m_rstn = 0; m_faultn = 1;
      cmp_on = 1;
    end else begin
      fall  = m_k3 && !m_k2;
      act   = m_rstn && supply_ok && !wd_dis;
      early = act && fall && win_mode && (m_cnt < WIN);
      good  = act && fall && !early;
      late  = act && !fall && (m_cnt == TMO - 1);
      flt   = early || late;
      if (!supply_ok || flt) begin
        m_rstn = 0; m_hold = 0;
      end else if (!m_rstn) begin
        m_hold++;
        if (m_hold == RPL) m_rstn = 1;
      end
      if (!act || fall || late) m_cnt = 0; else m_cnt++;
      if (flt) begin
        m_good = 0;
        if (m_bad < 3) m_bad++;
        if (m_bad == 3) m_faultn = 0;
      end else if (good) begin
        m_bad = 0;
        if (!m_faultn) begin
          m_good++;
          if (m_good == 3) begin m_faultn = 1; m_good = 0; end
        end
      end
      m_k3 = m_k2; m_k2 = m_k1; m_k1 = kick;
    end
  end

  task automatic check(string req, string what, logic act, logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic check_int(string req, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (cmp_on && !done) begin
      check(tag, "rst_n_o vs model", rst_n, m_rstn);
      check(tag, "fault_n_o vs model", fault_n, m_faultn);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic kick_now();
    @(negedge clk) kick = 0;
    @(negedge clk);
    @(negedge clk) kick = 1;
    @(negedge clk);
  endtask

  task automatic wait_release();
    for (int i = 0; i < 200 && !rst_n; i++) @(negedge clk);
  endtask

  task automatic do_good();
    wait_release();
    repeat (8) @(negedge clk);
    kick_now();
  endtask

  task automatic do_fault(bit extra_kicks);
    wait_release();
    kick_now();
    if (extra_kicks) begin kick_now(); kick_now(); end
    wait_release();
  endtask

  task automatic count_low(int n, output int lows);
    lows = 0;
    repeat (n) begin
      @(negedge clk);
      if (!rst_n) lows++;
    end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung run, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  // ---------------- directed sequence ----------------
  initial begin
    int lows;
    repeat (3) @(negedge clk);
    tag = "R1";
    check("R1", "rst_n_o in reset", rst_n, 1'b0);
    check("R1", "fault_n_o in reset", fault_n, 1'b1);
    rst = 0;
    count_low(14, lows);
    check_int("R1", "low samples after reset", lows, RPL - 1);

    tag = "R4";
    repeat (6) do_good();
    check("R4", "reset held off by kicks", rst_n, 1'b1);

    tag = "R2";
    @(negedge clk) kick = 0;
    repeat (6) @(negedge clk);
    kick = 1;
    kick_now();
    check("R2", "long low counted once", rst_n, 1'b1);

    tag = "R3";
    count_low(34, lows);
    check_int("R3", "timeout pulse length", lows, RPL);
    check("R3", "one fault keeps fault_n high", fault_n, 1'b1);
    do_good();

    tag = "R5";
    kick_now();
    kick_now();
    check("R5", "fast kicks fine in timeout mode", rst_n, 1'b1);
    win_mode = 1;
    do_good();
    kick_now();
    check("R5", "early kick starts reset", rst_n, 1'b0);

    tag = "R7";
    do_fault(0);
    check("R7", "two faults keep fault_n high", fault_n, 1'b1);
    do_fault(0);
    check("R7", "third fault asserts fault_n", fault_n, 1'b0);

    tag = "R6";
    do_fault(1);
    do_good();
    check("R6", "kicks in reset not counted", fault_n, 1'b0);

    tag = "R8";
    do_good();
    check("R8", "two goods not enough", fault_n, 1'b0);
    do_fault(0);
    do_good();
    do_good();
    check("R8", "run restarted by fault", fault_n, 1'b0);
    do_good();
    check("R8", "three goods release", fault_n, 1'b1);

    tag = "R9";
    do_fault(0);
    do_fault(0);
    do_good();
    do_fault(0);
    do_fault(0);
    check("R9", "good kick broke fault run", fault_n, 1'b1);
    do_good();

    tag = "R10";
    do_fault(0);
    do_fault(0);
    do_good();
    do_fault(0);
    do_fault(0);
    @(negedge clk) supply_ok = 0;
    count_low(30, lows);
    check_int("R10", "reset low while supply low", lows, 30);
    check("R10", "fault_n not asserted on low supply", fault_n, 1'b1);
    supply_ok = 1;
    count_low(14, lows);
    check_int("R10", "low samples after supply return", lows, RPL - 1);
    do_good();

    tag = "R11";
    @(negedge clk) wd_dis = 1;
    count_low(60, lows);
    check_int("R11", "no reset while disabled", lows, 0);
    check("R11", "fault_n unchanged while disabled", fault_n, 1'b1);

    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule